// File: doc/BRIEF.md
# Serial EEPROM Burst Read Controller

This block fetches a run of consecutive 16-bit words from a three-wire serial EEPROM. The host supplies a first address, a word count and a one-cycle go strobe. The controller drives the chip select, serial clock and serial data lines. For every word it sends a complete, separately framed read command. It samples the returning bit stream and delivers each finished word with a one-cycle valid strobe.

Each word uses its own frame:
- Chip select rises and is held for one serial clock period with no command bits.
- The command bits 1, 1, 0 follow, then the word address, MSB first.
- Seventeen bits are read back. The first is a dummy zero and is dropped.
- Chip select drops for one full serial clock period before the next frame starts.

The serial clock is derived from the system clock. Two parameters give the low phase and the high phase lengths in system cycles. They are sized so that the device's minimum phase times and chip-select setup time are met. The address width is a parameter, normally 6 or 8.

Top module: `seeprom_burst_rd`

## Requirements
- R1: While reset is asserted, cs_o, sk_o, dout_o, busy_o, done_o and word_valid_o are 0 and word_o is 0.
- R2: Each frame starts with cs_o rising while sk_o is low. Exactly one sk_o rising edge then occurs with dout_o at 0. The following rising edges carry the bits 1, 1, 0 and then ADDR_W address bits, MSB first. The device takes each bit on the sk_o rising edge.
- R3: After the address, 17 bits are taken from din_i, one per serial clock, just before each sk_o rising edge. The first bit is discarded and the other 16 form word_o, MSB first. word_o is updated together with a one-cycle word_valid_o pulse and holds its value between pulses.
- R4: The words are read from addresses start, start+1, …, start+count-1. The address wraps modulo 2^ADDR_W.
- R5: After every word, cs_o is low for exactly one sk_o rising edge before the next frame, or before completion.
- R6: Every sk_o low phase lasts LO_CYC system cycles and every high phase lasts HI_CYC cycles. A word takes (ADDR_W+22)·(LO_CYC+HI_CYC) cycles. done_o is seen exactly count times that many cycles after the edge that accepts go_i.
- R7: dout_o changes only while sk_o is low.
- R8: busy_o is high from the cycle after an accepted go_i until completion. done_o is a one-cycle pulse in the cycle in which busy_o falls.
- R9: A go_i received while busy_o is high has no effect. This includes the edge at which the burst completes. No new burst starts afterwards.
- R10: A go_i with a count of 0 gives a done_o pulse in the next cycle. busy_o and cs_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start strobe, taken only when idle |
| start_addr_i | input | ADDR_W | First word address |
| count_i | input | CNT_W | Number of words to read |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 16 | Last word assembled |
| word_valid_o | output | 1 | One-cycle strobe for a new word_o |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| dout_o | output | 1 | Serial data to the EEPROM |
| din_i | input | 1 | Serial data from the EEPROM |

## Verification
A go strobe can coincide with the completion of a burst: done_o rises from the same edge that samples go_i. Because the bench knows the exact burst length from R6, it drives go_i in the last cycle of a burst and in the middle of one. It then judges that the completion edge still gives a single done_o, and that busy_o and cs_o stay low afterwards. A behavioural EEPROM model in the bench decodes the command and address from the pins. It answers with a known address-dependent pattern, so that dropped or shifted dummy bits show up as wrong words.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int DATA_W    = 16;
  localparam int READ_BITS = DATA_W + 1;  // dummy zero plus data
  localparam logic [2:0] READ_CMD = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEND,
    ST_READ,
    ST_TAIL
  } rd_state_e;
endpackage

// File: rtl/seeprom_phase_gen.sv
module seeprom_phase_gen #(
  parameter int LO_CYC = 30,
  parameter int HI_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sk_o,
  output logic lo_end_o,
  output logic hi_end_o
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  assign lo_end_o = run_i && !ph_q && (cnt_q == CW'(LO_CYC - 1));
  assign hi_end_o = run_i &&  ph_q && (cnt_q == CW'(HI_CYC - 1));
  assign sk_o     = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (lo_end_o) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (hi_end_o) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/seeprom_rx_shift.sv
module seeprom_rx_shift
  import seeprom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              din_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] word_o
);
  // 17 samples through a 16-bit register push the dummy bit out the top
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      if (sample_i) shift_q <= {shift_q[DATA_W-2:0], din_i};
      if (load_i)   word_q  <= shift_q;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/seeprom_burst_rd.sv
module seeprom_burst_rd
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = ADDR_W + 1,
  parameter int LO_CYC = 30,
  parameter int HI_CYC = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              dout_o,
  input  logic              din_i
);
  localparam int TX_W    = 3 + ADDR_W;
  localparam int BIT_MAX = (TX_W > READ_BITS) ? TX_W : READ_BITS;
  localparam int BC_W    = $clog2(BIT_MAX + 1);

  rd_state_e         state_q;
  logic [BC_W-1:0]   bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [TX_W-1:0]   tx_q;
  logic              busy_q, done_q, valid_q;
  logic              run, lo_end, hi_end, sample, load;

  assign run    = (state_q != ST_IDLE);
  assign sample = lo_end && (state_q == ST_READ);
  assign load   = hi_end && (state_q == ST_READ) && (bit_q == BC_W'(READ_BITS - 1));

  seeprom_phase_gen #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sk_o     (sk_o),
    .lo_end_o (lo_end),
    .hi_end_o (hi_end)
  );

  seeprom_rx_shift u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .din_i    (din_i),
    .load_i   (load),
    .word_o   (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      tx_q    <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          if (count_i == '0) begin
            done_q <= 1'b1;
          end else begin
            addr_q  <= start_addr_i;
            left_q  <= count_i;
            busy_q  <= 1'b1;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: if (hi_end) begin
          tx_q    <= {READ_CMD, addr_q};
          bit_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: if (hi_end) begin
          tx_q <= tx_q << 1;
          if (bit_q == BC_W'(TX_W - 1)) begin
            bit_q   <= '0;
            state_q <= ST_READ;
          end else begin
            bit_q <= bit_q + BC_W'(1);
          end
        end
        ST_READ: if (hi_end) begin
          if (bit_q == BC_W'(READ_BITS - 1)) begin
            valid_q <= 1'b1;
            state_q <= ST_TAIL;
          end else begin
            bit_q <= bit_q + BC_W'(1);
          end
        end
        ST_TAIL: if (hi_end) begin
          if (left_q == CNT_W'(1)) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            addr_q  <= addr_q + ADDR_W'(1);
            state_q <= ST_SEL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o         = (state_q == ST_SEL) || (state_q == ST_SEND) || (state_q == ST_READ);
  assign dout_o       = (state_q == ST_SEND) && tx_q[TX_W-1];
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign word_valid_o = valid_q;
endmodule

module seeprom_burst_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] word_o,
  input logic        word_valid_o,
  input logic        cs_o,
  input logic        sk_o,
  input logic        dout_o
);
  a_r10_idle_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cs_o && !sk_o));
  a_r2_cs_rise_sk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sk_o);
  a_r7_dout_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> !sk_o);
  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
  a_r3_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_fall_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
endmodule

bind seeprom_burst_rd seeprom_burst_rd_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .cs_o         (cs_o),
  .sk_o         (sk_o),
  .dout_o       (dout_o)
);

// File: tb/seeprom_burst_rd_test.sv
module seeprom_burst_rd_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int CNT_W      = 7;
  localparam int LO_CYC     = 2;
  localparam int HI_CYC     = 3;
  localparam int WORD_CYC   = (ADDR_W + 22) * (LO_CYC + HI_CYC);
  localparam int AMASK      = (1 << ADDR_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, din = 1'b0;
  logic [ADDR_W-1:0] start_a = '0;
  logic [CNT_W-1:0]  cnt = '0;
  logic busy, done, wv, cs, sk, dout;
  logic [15:0] word;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seeprom_burst_rd #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .start_addr_i(start_a), .count_i(cnt),
    .busy_o(busy), .done_o(done), .word_o(word), .word_valid_o(wv),
    .cs_o(cs), .sk_o(sk), .dout_o(dout), .din_i(din)
  );

  function automatic logic [15:0] mem_fn(int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // EEPROM model and pin monitors
  int addr_log[256], n_addr = 0, n_word = 0;
  logic [15:0] word_log[256];
  int frame_err = 0, gap_err = 0, phase_err = 0, dout_err = 0, done_cnt = 0;
  logic sk_d = 1'b0, cs_d = 1'b0, dout_d = 1'b0;
  int st = 0, nb = 0, acc = 0, rise_pre = 0, gap_rise = 0, hi_len = 0, lo_len = 0;
  bit had_gap = 0, seen_fall = 0;
  logic [15:0] sh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wv && n_word < 256) begin word_log[n_word] = word; n_word++; end
      if (sk && !sk_d) begin
        if (seen_fall && lo_len != LO_CYC) phase_err++;
        hi_len = 1;
      end else if (sk) hi_len++;
      if (!sk && sk_d) begin
        if (hi_len != HI_CYC) phase_err++;
        lo_len = 1; seen_fall = 1;
      end else if (!sk) lo_len++;
      if (!busy && !sk) seen_fall = 0;
      if (sk && sk_d && dout != dout_d) dout_err++;
      if (cs && !cs_d) begin
        if (had_gap && gap_rise != 1) gap_err++;
        st = 0; rise_pre = 0; had_gap = 0;
      end
      if (!cs && cs_d) begin gap_rise = 0; had_gap = 1; din = 1'b0; end
      if (sk && !sk_d) begin
        if (!cs) gap_rise++;
        else case (st)
          0: if (dout) begin
               st = 1; nb = 0; acc = 0;
               if (rise_pre != 1) frame_err++;
             end else rise_pre++;
          1: begin
               acc = acc * 2 + int'(dout); nb++;
               if (nb == 2 + ADDR_W) begin
                 if ((acc >> ADDR_W) != 2) frame_err++;
                 if (n_addr < 256) begin addr_log[n_addr] = acc & AMASK; n_addr++; end
                 sh = mem_fn(acc & AMASK); st = 2; nb = 0; din = 1'b0;
               end
             end
          2: begin
               if (nb < 16) begin din = sh[15]; sh = sh << 1; end else din = 1'b0;
               nb++;
             end
          default: ;
        endcase
      end
      if (done) begin
        done_cnt++;
        if (had_gap && gap_rise != 1) gap_err++;
        had_gap = 0;
      end
      sk_d = sk; cs_d = cs; dout_d = dout;
    end
  end

  task automatic run_burst(int s, int c, int ign_at);
    int a0 = n_addr, w0 = n_word, fe = frame_err, ge = gap_err;
    int pe = phase_err, de = dout_err, dc = done_cnt, cyc = 0, bad_w = 0, bad_a = 0;
    @(negedge clk); start_a = ADDR_W'(s); cnt = CNT_W'(c); go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (c == 0) begin
      check(done && !busy && !cs, "R10", "zero count immediate done", int'(done), 1);
      @(negedge clk);
      check(!done && !busy && !cs, "R10", "zero count stays idle", int'(busy), 0);
      check(n_addr == a0 && n_word == w0, "R10", "zero count no frame", n_addr - a0, 0);
      return;
    end
    check(busy, "R8", "busy after go", int'(busy), 1);
    while (!done && cyc < 100000) begin
      go = (ign_at > 0 && cyc == ign_at);
      if (go) begin start_a = start_a ^ ADDR_W'(5); cnt = CNT_W'(3); end
      @(negedge clk); cyc++;
    end
    go = 1'b0;
    check(cyc == c * WORD_CYC, "R6", "burst duration", cyc, c * WORD_CYC);
    check(!busy, "R8", "busy falls with done", int'(busy), 0);
    check(n_word - w0 == c, "R3", "word count", n_word - w0, c);
    check(n_addr - a0 == c, "R4", "frame count", n_addr - a0, c);
    for (int i = 0; i < c; i++) begin
      if (addr_log[a0 + i] != ((s + i) & AMASK)) bad_a++;
      if (word_log[w0 + i] != mem_fn((s + i) & AMASK)) bad_w++;
    end
    check(bad_a == 0, "R4", "address sequence mismatches", bad_a, 0);
    check(bad_w == 0, "R3", "word data mismatches", bad_w, 0);
    check(frame_err == fe, "R2", "frame format errors", frame_err - fe, 0);
    check(gap_err == ge, "R5", "deselect gap errors", gap_err - ge, 0);
    check(phase_err == pe, "R6", "phase width errors", phase_err - pe, 0);
    check(dout_err == de, "R7", "dout moved with sk high", dout_err - de, 0);
    repeat (3) @(negedge clk);
    check(done_cnt - dc == 1, "R8", "done pulses", done_cnt - dc, 1);
    check(!busy && !cs && n_addr - a0 == c, "R9", "no burst after ignored go", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!cs && !sk && !dout && !busy && !done && !wv && word == 16'h0,
          "R1", "reset outputs", int'(word), 0);
    rst_n = 1'b1;
    run_burst(0, 1, 0);
    run_burst(62, 4, 0);                 // address wrap R4
    run_burst(0, 0, 0);                  // R10
    run_burst(10, 3, 60);                // go mid-burst R9
    run_burst(20, 2, 2 * WORD_CYC - 1);  // go on the completion edge R9
    run_burst(63, 1, 0);
    for (int k = 0; k < 6; k++)
      run_burst(int'($urandom_range(0, AMASK)), int'($urandom_range(1, 4)), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule